// File: doc/BRIEF.md
# Five-Channel Multi-Mode DMA Controller

This block moves data between memory locations on behalf of five independent channels that share one memory master port. A channel is set up by presenting its configuration on the `cfg_*` inputs and pulsing its bit of `cfg_load_i`. The configuration holds source and destination addresses, a unit count, a unit size, an address direction for each side, a trigger selector, a transfer mode, a block length and an interrupt enable. Each transferred unit is one read of the source address followed by one write of the read data to the destination address. Both accesses use a request/acknowledge handshake.

Four sequencing modes decide how trigger activity turns into units. Demand mode runs while the selected request line is held high. Burst mode runs the whole count after one trigger edge. Step mode moves one unit per trigger edge. Block mode moves a programmed number of units per edge. Channels compete under a fixed priority, and the grant is only reconsidered between units. When a channel's count runs out it raises its done flag, drops its enable and, if allowed, its interrupt.

Top module: `mdma_top`

## Requirements
- R1: After reset `mem_req_o` is low and every bit of `en_o`, `done_o` and `irq_o` is low.
- R2: A `cfg_load_i` pulse latches that channel's configuration and clears its done flag. It sets the enable only if the loaded count is nonzero. A channel loaded with count zero stays disabled and ignores all triggers.
- R3: Each unit issues a read (`mem_we_o`=0) at the current source address and then a write (`mem_we_o`=1) of the read data at the current destination address. The write follows the read's acknowledge. `mem_size_o` carries the size code: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit. A request holds its address and direction until acknowledged.
- R4: After each unit, source and destination step independently by the unit size in bytes (1, 2 or 4). The address-mode codes are 0 = increment, 1 = decrement, 2 = fixed. Addresses wrap modulo 2^32.
- R5: Each unit decrements the count. After the unit that brings it to zero, the done flag rises and the enable falls, and the two are never high together.
- R6: `irq_o` of a channel is high exactly when its done flag is set and its interrupt enable was set at load time.
- R7: The trigger selector picks one source: 0 = external pin (`ext_req_i`), 1 = peripheral line (`per_req_i`), 2 = software start (`sw_start_i`), 3 = none. Activity on the sources not selected has no effect.
- R8: Mode 0 (demand) moves units only while the selected line is high. After the line drops, the unit in progress completes and no further unit starts.
- R9: Mode 1 (burst) moves the whole remaining count after one rising trigger edge.
- R10: Mode 2 (step) moves exactly one unit per rising trigger edge.
- R11: Mode 3 (block) moves the block length (nonzero) in units per rising trigger edge. The last block is cut short by the count.
- R12: At most one channel holds the grant (`gnt_o`). When several channels want the port, the lowest index wins. A grant never changes in the middle of a unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | NCH | Per-channel configuration load strobe |
| cfg_src_i | input | NCH x AW | Source start address per channel |
| cfg_dst_i | input | NCH x AW | Destination start address per channel |
| cfg_cnt_i | input | NCH x CW | Unit count per channel |
| cfg_blk_i | input | NCH x BW | Units per trigger in block mode |
| cfg_mode_i | input | NCH x 2 | Mode: 0 demand, 1 burst, 2 step, 3 block |
| cfg_size_i | input | NCH x 2 | Unit size code |
| cfg_sam_i | input | NCH x 2 | Source address mode |
| cfg_dam_i | input | NCH x 2 | Destination address mode |
| cfg_trig_i | input | NCH x 2 | Trigger selector |
| cfg_ie_i | input | NCH | Interrupt enable |
| ext_req_i | input | NCH | External request pins |
| per_req_i | input | NCH | Peripheral request lines |
| sw_start_i | input | NCH | Software start pulses |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Access address |
| mem_size_o | output | 2 | Access size code |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Access acknowledge |
| gnt_o | output | NCH | One-hot channel owning the port |
| en_o | output | NCH | Channel enables |
| done_o | output | NCH | Channel done flags |
| irq_o | output | NCH | Channel interrupts |

## Verification
Some rules are checked by assertions on every cycle. Only one grant exists at a time, and a grant is frozen until its unit's write is acknowledged. A newly taken grant goes to the lowest-index requester. A pending request keeps its address and direction, and every acknowledged read is followed directly by a write. A finished channel never stays enabled, and no interrupt appears without done. Other behaviour only shows up in the bench's scenarios. These cover the exact address sequences for each size and direction, including wrap, and the data carried from read to write. They also cover how many units each mode moves per trigger edge, and that unselected sources and zero counts are ignored. The order in which competing channels drain is checked the same way.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

  typedef enum logic [1:0] {
    MODE_DEMAND = 2'd0,
    MODE_BURST  = 2'd1,
    MODE_STEP   = 2'd2,
    MODE_BLOCK  = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    AM_INC = 2'd0,
    AM_DEC = 2'd1,
    AM_FIX = 2'd2,
    AM_RSV = 2'd3
  } addr_mode_e;

  typedef enum logic [1:0] {
    TS_PIN    = 2'd0,
    TS_PERIPH = 2'd1,
    TS_SOFT   = 2'd2,
    TS_NONE   = 2'd3
  } trig_sel_e;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RD   = 2'd1,
    ENG_WR   = 2'd2
  } eng_state_e;

  // bytes moved by one unit for a size code
  function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/mdma_chan.sv
module mdma_chan
  import mdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [BW-1:0] blk_i,
  input  logic [1:0]    mode_i,
  input  logic [1:0]    size_i,
  input  logic [1:0]    sam_i,
  input  logic [1:0]    dam_i,
  input  logic [1:0]    trig_i,
  input  logic          ie_i,
  input  logic          ext_i,
  input  logic          per_i,
  input  logic          sw_i,
  input  logic          unit_done_i,
  output logic          want_o,
  output logic          en_o,
  output logic          done_o,
  output logic          irq_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [1:0]    size_o
);

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a,
                                              input addr_mode_e am,
                                              input logic [1:0] sz);
    logic [AW-1:0] delta;
    delta = AW'(unit_bytes(sz));
    case (am)
      AM_INC:  return a + delta;
      AM_DEC:  return a - delta;
      default: return a;
    endcase
  endfunction

  xfer_mode_e    mode_q;
  addr_mode_e    sam_q, dam_q;
  trig_sel_e     trig_q;
  logic [1:0]    size_q;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] blk_len_q, blk_q;
  logic          en_q, done_q, ie_q, pend_q, sel_q;
  logic          sel_lvl, trig_edge, last_unit;

  always_comb begin
    case (trig_q)
      TS_PIN:    sel_lvl = ext_i;
      TS_PERIPH: sel_lvl = per_i;
      TS_SOFT:   sel_lvl = sw_i;
      default:   sel_lvl = 1'b0;
    endcase
  end

  assign trig_edge = sel_lvl & ~sel_q;
  assign last_unit = unit_done_i && (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_DEMAND;
      sam_q     <= AM_INC;
      dam_q     <= AM_INC;
      trig_q    <= TS_NONE;
      size_q    <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      cnt_q     <= '0;
      blk_len_q <= '0;
      blk_q     <= '0;
      en_q      <= 1'b0;
      done_q    <= 1'b0;
      ie_q      <= 1'b0;
      pend_q    <= 1'b0;
      sel_q     <= 1'b0;
    end else begin
      sel_q <= sel_lvl;
      if (load_i) begin
        mode_q    <= xfer_mode_e'(mode_i);
        sam_q     <= addr_mode_e'(sam_i);
        dam_q     <= addr_mode_e'(dam_i);
        trig_q    <= trig_sel_e'(trig_i);
        size_q    <= size_i;
        src_q     <= src_i;
        dst_q     <= dst_i;
        cnt_q     <= cnt_i;
        blk_len_q <= blk_i;
        blk_q     <= '0;
        ie_q      <= ie_i;
        en_q      <= (cnt_i != '0);
        done_q    <= 1'b0;
        pend_q    <= 1'b0;
      end else if (unit_done_i) begin
        src_q <= next_addr(src_q, sam_q, size_q);
        dst_q <= next_addr(dst_q, dam_q, size_q);
        cnt_q <= cnt_q - CW'(1);
        if (last_unit) begin
          en_q   <= 1'b0;
          done_q <= 1'b1;
          pend_q <= 1'b0;
        end else begin
          case (mode_q)
            MODE_STEP: pend_q <= 1'b0;
            MODE_BLOCK: begin
              blk_q <= blk_q - BW'(1);
              if (blk_q == BW'(1)) pend_q <= 1'b0;
            end
            default: ;
          endcase
        end
      end else if (trig_edge && en_q && !pend_q && (mode_q != MODE_DEMAND)) begin
        pend_q <= 1'b1;
        blk_q  <= blk_len_q;
      end
    end
  end

  assign want_o = en_q & ((mode_q == MODE_DEMAND) ? sel_lvl : pend_q);
  assign en_o   = en_q;
  assign done_o = done_q;
  assign irq_o  = done_q & ie_q;
  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign size_o = size_q;

endmodule

// File: rtl/mdma_arb.sv
module mdma_arb #(
  parameter int NCH = 5
) (
  input  logic [NCH-1:0] want_i,
  output logic [NCH-1:0] pick_o
);

  always_comb begin
    logic found;
    found  = 1'b0;
    pick_o = '0;
    for (int i = 0; i < NCH; i++) begin
      if (want_i[i] && !found) begin
        pick_o[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end

endmodule

// File: rtl/mdma_engine.sv
module mdma_engine
  import mdma_pkg::*;
#(
  parameter int NCH = 5,
  parameter int AW  = 32,
  parameter int DW  = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NCH-1:0]          pick_i,
  input  logic [NCH-1:0][AW-1:0]  src_i,
  input  logic [NCH-1:0][AW-1:0]  dst_i,
  input  logic [NCH-1:0][1:0]     size_i,
  input  logic                    mem_ack_i,
  input  logic [DW-1:0]           mem_rdata_i,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [AW-1:0]           mem_addr_o,
  output logic [1:0]              mem_size_o,
  output logic [DW-1:0]           mem_wdata_o,
  output logic [NCH-1:0]          gnt_o,
  output logic                    unit_done_o
);

  eng_state_e     st_q;
  logic [NCH-1:0] gnt_q;
  logic [DW-1:0]  data_q;
  logic [AW-1:0]  src_m, dst_m;
  logic [1:0]     size_m;

  always_comb begin
    src_m  = '0;
    dst_m  = '0;
    size_m = '0;
    for (int i = 0; i < NCH; i++) begin
      if (gnt_q[i]) begin
        src_m  = src_i[i];
        dst_m  = dst_i[i];
        size_m = size_i[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ENG_IDLE;
      gnt_q  <= '0;
      data_q <= '0;
    end else begin
      case (st_q)
        ENG_IDLE: if (pick_i != '0) begin
          gnt_q <= pick_i;
          st_q  <= ENG_RD;
        end
        ENG_RD: if (mem_ack_i) begin
          data_q <= mem_rdata_i;
          st_q   <= ENG_WR;
        end
        ENG_WR: if (mem_ack_i) begin
          gnt_q <= '0;
          st_q  <= ENG_IDLE;
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (st_q == ENG_RD) || (st_q == ENG_WR);
  assign mem_we_o    = (st_q == ENG_WR);
  assign mem_addr_o  = (st_q == ENG_WR) ? dst_m : src_m;
  assign mem_size_o  = size_m;
  assign mem_wdata_o = data_q;
  assign gnt_o       = gnt_q;
  assign unit_done_o = (st_q == ENG_WR) && mem_ack_i;

endmodule

// File: rtl/mdma_top.sv
module mdma_top
  import mdma_pkg::*;
#(
  parameter int NCH = 5,
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int CW  = 16,
  parameter int BW  = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NCH-1:0]         cfg_load_i,
  input  logic [NCH-1:0][AW-1:0] cfg_src_i,
  input  logic [NCH-1:0][AW-1:0] cfg_dst_i,
  input  logic [NCH-1:0][CW-1:0] cfg_cnt_i,
  input  logic [NCH-1:0][BW-1:0] cfg_blk_i,
  input  logic [NCH-1:0][1:0]    cfg_mode_i,
  input  logic [NCH-1:0][1:0]    cfg_size_i,
  input  logic [NCH-1:0][1:0]    cfg_sam_i,
  input  logic [NCH-1:0][1:0]    cfg_dam_i,
  input  logic [NCH-1:0][1:0]    cfg_trig_i,
  input  logic [NCH-1:0]         cfg_ie_i,
  input  logic [NCH-1:0]         ext_req_i,
  input  logic [NCH-1:0]         per_req_i,
  input  logic [NCH-1:0]         sw_start_i,
  output logic                   mem_req_o,
  output logic                   mem_we_o,
  output logic [AW-1:0]          mem_addr_o,
  output logic [1:0]             mem_size_o,
  output logic [DW-1:0]          mem_wdata_o,
  input  logic [DW-1:0]          mem_rdata_i,
  input  logic                   mem_ack_i,
  output logic [NCH-1:0]         gnt_o,
  output logic [NCH-1:0]         en_o,
  output logic [NCH-1:0]         done_o,
  output logic [NCH-1:0]         irq_o
);

  logic [NCH-1:0]         want_w;
  logic [NCH-1:0]         pick_w;
  logic [NCH-1:0]         gnt_w;
  logic [NCH-1:0]         chan_done_unit_w;
  logic [NCH-1:0][AW-1:0] src_w, dst_w;
  logic [NCH-1:0][1:0]    size_w;
  logic                   unit_done_w;

  assign chan_done_unit_w = gnt_w & {NCH{unit_done_w}};

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    mdma_chan #(.AW(AW), .CW(CW), .BW(BW)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (cfg_load_i[g]),
      .src_i       (cfg_src_i[g]),
      .dst_i       (cfg_dst_i[g]),
      .cnt_i       (cfg_cnt_i[g]),
      .blk_i       (cfg_blk_i[g]),
      .mode_i      (cfg_mode_i[g]),
      .size_i      (cfg_size_i[g]),
      .sam_i       (cfg_sam_i[g]),
      .dam_i       (cfg_dam_i[g]),
      .trig_i      (cfg_trig_i[g]),
      .ie_i        (cfg_ie_i[g]),
      .ext_i       (ext_req_i[g]),
      .per_i       (per_req_i[g]),
      .sw_i        (sw_start_i[g]),
      .unit_done_i (chan_done_unit_w[g]),
      .want_o      (want_w[g]),
      .en_o        (en_o[g]),
      .done_o      (done_o[g]),
      .irq_o       (irq_o[g]),
      .src_o       (src_w[g]),
      .dst_o       (dst_w[g]),
      .size_o      (size_w[g])
    );
  end

  mdma_arb #(.NCH(NCH)) u_arb (
    .want_i (want_w),
    .pick_o (pick_w)
  );

  mdma_engine #(.NCH(NCH), .AW(AW), .DW(DW)) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pick_i      (pick_w),
    .src_i       (src_w),
    .dst_i       (dst_w),
    .size_i      (size_w),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_size_o  (mem_size_o),
    .mem_wdata_o (mem_wdata_o),
    .gnt_o       (gnt_w),
    .unit_done_o (unit_done_w)
  );

  assign gnt_o = gnt_w;

endmodule

// File: rtl/mdma_chk.sv
module mdma_chk #(
  parameter int NCH = 5,
  parameter int AW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] want,
  input logic [NCH-1:0] gnt,
  input logic           unit_done,
  input logic           mem_req,
  input logic           mem_we,
  input logic           mem_ack,
  input logic [AW-1:0]  mem_addr,
  input logic [NCH-1:0] done,
  input logic [NCH-1:0] en,
  input logic [NCH-1:0] irq
);

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R12

  AST_GNT_HELD_IN_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && !unit_done) |=> $stable(gnt)); // R12

  AST_PRIO_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && want != '0) |=> (gnt != '0 && (($past(want) & (gnt - NCH'(1))) == '0))); // R12

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R3

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we)); // R3

  AST_DONE_NOT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ((done & en) == '0)); // R5

  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~done) == '0)); // R6

endmodule

bind mdma_top mdma_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk       (clk_i),
  .rst_n     (rst_ni),
  .want      (want_w),
  .gnt       (gnt_w),
  .unit_done (unit_done_w),
  .mem_req   (mem_req_o),
  .mem_we    (mem_we_o),
  .mem_ack   (mem_ack_i),
  .mem_addr  (mem_addr_o),
  .done      (done_o),
  .en        (en_o),
  .irq       (irq_o)
);

// File: tb/mdma_top_tb.sv
module mdma_top_tb;

  localparam int NCH = 5;
  localparam int LOGN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NCH-1:0]         cfg_load = '0;
  logic [NCH-1:0][31:0]   cfg_src = '0, cfg_dst = '0;
  logic [NCH-1:0][15:0]   cfg_cnt = '0;
  logic [NCH-1:0][7:0]    cfg_blk = '0;
  logic [NCH-1:0][1:0]    cfg_mode = '0, cfg_size = '0, cfg_sam = '0, cfg_dam = '0, cfg_trig = '0;
  logic [NCH-1:0]         cfg_ie = '0, ext_req = '0, per_req = '0, sw_start = '0;
  logic                   mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0]            mem_addr, mem_wdata, mem_rdata = '0;
  logic [1:0]             mem_size;
  logic [NCH-1:0]         gnt, en, done, irq;

  mdma_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(cfg_load), .cfg_src_i(cfg_src),
    .cfg_dst_i(cfg_dst), .cfg_cnt_i(cfg_cnt), .cfg_blk_i(cfg_blk), .cfg_mode_i(cfg_mode),
    .cfg_size_i(cfg_size), .cfg_sam_i(cfg_sam), .cfg_dam_i(cfg_dam), .cfg_trig_i(cfg_trig),
    .cfg_ie_i(cfg_ie), .ext_req_i(ext_req), .per_req_i(per_req), .sw_start_i(sw_start),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_size_o(mem_size),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
    .gnt_o(gnt), .en_o(en), .done_o(done), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0, n_log = 0;
  bit finished = 1'b0;
  logic [31:0] lg_addr [LOGN];
  logic [31:0] lg_data [LOGN];
  logic        lg_we   [LOGN];
  logic [1:0]  lg_size [LOGN];
  int          lg_ch   [LOGN];

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h5A5A_0000;
  endfunction

  function automatic int ch_of(input logic [NCH-1:0] g);
    for (int i = 0; i < NCH; i++) if (g[i]) return i;
    return -1;
  endfunction

  // i-th address of a sequence, restated as base plus signed multiple
  function automatic logic [31:0] nth(input logic [31:0] base, input logic [1:0] am,
                                      input logic [1:0] sz, input int i);
    int b;
    b = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    if (am == 2'd0) return base + 32'(i * b);
    if (am == 2'd1) return base - 32'(i * b);
    return base;
  endfunction

  // memory responder: acknowledges every access after one idle cycle, logs it
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        mem_ack   = 1'b1;
        mem_rdata = pat(mem_addr);
        if (n_log < LOGN) begin
          lg_addr[n_log] = mem_addr;
          lg_we[n_log]   = mem_we;
          lg_data[n_log] = mem_we ? mem_wdata : pat(mem_addr);
          lg_size[n_log] = mem_size;
          lg_ch[n_log]   = ch_of(gnt);
        end
        n_log++;
      end else begin
        mem_ack = 1'b0;
      end
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_ch(input int c, input logic [1:0] mode, input logic [1:0] size,
                         input logic [1:0] sam, input logic [1:0] dam, input logic [1:0] trig,
                         input logic [15:0] cnt, input logic [7:0] blk,
                         input logic [31:0] src, input logic [31:0] dst, input logic ie);
    cfg_mode[c] = mode; cfg_size[c] = size; cfg_sam[c] = sam; cfg_dam[c] = dam;
    cfg_trig[c] = trig; cfg_cnt[c] = cnt; cfg_blk[c] = blk; cfg_src[c] = src;
    cfg_dst[c] = dst; cfg_ie[c] = ie; cfg_load[c] = 1'b1;
    @(negedge clk);
    cfg_load[c] = 1'b0;
  endtask

  task automatic wait_done(input int c);
    for (int k = 0; k < 3000 && !done[c]; k++) @(negedge clk);
    tick(2);
  endtask

  typedef struct packed {
    logic [2:0]  ch;
    logic [1:0]  size;
    logic [1:0]  sam;
    logic [1:0]  dam;
    logic [7:0]  cnt;
    logic [31:0] src;
    logic [31:0] dst;
  } vec_t;

  localparam vec_t VT [6] = '{
    '{3'd1, 2'd2, 2'd0, 2'd0, 8'd4, 32'h0000_1000, 32'h0000_2000},
    '{3'd0, 2'd0, 2'd1, 2'd0, 8'd5, 32'h0000_3010, 32'h0000_4000},
    '{3'd4, 2'd1, 2'd2, 2'd1, 8'd3, 32'h0000_5000, 32'h0000_6006},
    '{3'd2, 2'd0, 2'd0, 2'd2, 8'd2, 32'hFFFF_FFFF, 32'h0000_0080},
    '{3'd3, 2'd1, 2'd0, 2'd0, 8'd1, 32'h0000_7002, 32'h0000_8004},
    '{3'd4, 2'd2, 2'd1, 2'd1, 8'd6, 32'h0000_0100, 32'h0000_0200}
  };

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1: reset state
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 en", 32'(en), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 irq", 32'(irq), 0);

    // Vector table: burst, software trigger, address sequences
    for (int v = 0; v < 6; v++) begin
      int c;
      c = int'(VT[v].ch);
      n_log = 0;
      load_ch(c, 2'd1, VT[v].size, VT[v].sam, VT[v].dam, 2'd2, 16'(VT[v].cnt), 8'd1,
              VT[v].src, VT[v].dst, 1'b1);
      chk("R2 enable after load", 32'(en[c]), 1);
      sw_start[c] = 1'b1; tick(1); sw_start[c] = 1'b0;
      wait_done(c);
      chk("R9 burst unit count", 32'(n_log), 32'(2 * int'(VT[v].cnt)));
      for (int i = 0; i < int'(VT[v].cnt); i++) begin
        chk("R4 src addr", lg_addr[2*i], nth(VT[v].src, VT[v].sam, VT[v].size, i));
        chk("R3 read dir", 32'(lg_we[2*i]), 0);
        chk("R4 dst addr", lg_addr[2*i+1], nth(VT[v].dst, VT[v].dam, VT[v].size, i));
        chk("R3 write dir", 32'(lg_we[2*i+1]), 1);
        chk("R3 data", lg_data[2*i+1], pat(nth(VT[v].src, VT[v].sam, VT[v].size, i)));
        chk("R3 size", 32'(lg_size[2*i+1]), 32'(VT[v].size));
        chk("R12 channel", 32'(lg_ch[2*i]), 32'(c));
      end
      chk("R5 done", 32'(done[c]), 1);
      chk("R5 enable cleared", 32'(en[c]), 0);
      chk("R6 irq", 32'(irq[c]), 1);
    end

    // R2: zero count stays disabled, triggers ignored
    n_log = 0;
    load_ch(1, 2'd1, 2'd2, 2'd0, 2'd0, 2'd2, 16'd0, 8'd1, 32'h100, 32'h200, 1'b1);
    chk("R2 zero count enable", 32'(en[1]), 0);
    sw_start[1] = 1'b1; tick(1); sw_start[1] = 1'b0;
    tick(20);
    chk("R2 zero count no access", 32'(n_log), 0);
    chk("R2 zero count done", 32'(done[1]), 0);

    // R7: unselected sources ignored; R6 irq disabled
    n_log = 0;
    load_ch(2, 2'd1, 2'd2, 2'd0, 2'd0, 2'd0, 16'd2, 8'd1, 32'h900, 32'hA00, 1'b0);
    sw_start[2] = 1'b1; per_req[2] = 1'b1; tick(1);
    sw_start[2] = 1'b0; per_req[2] = 1'b0;
    tick(20);
    chk("R7 unselected ignored", 32'(n_log), 0);
    chk("R7 still enabled", 32'(en[2]), 1);
    ext_req[2] = 1'b1; tick(1); ext_req[2] = 1'b0;
    wait_done(2);
    chk("R7 selected pin starts", 32'(n_log), 4);
    chk("R6 irq masked", 32'(irq[2]), 0);
    chk("R6 done set", 32'(done[2]), 1);

    // R10: step mode, peripheral trigger
    n_log = 0;
    load_ch(3, 2'd2, 2'd0, 2'd0, 2'd0, 2'd1, 16'd3, 8'd1, 32'hB00, 32'hC00, 1'b1);
    per_req[3] = 1'b1; tick(1); per_req[3] = 1'b0;
    tick(30);
    chk("R10 one unit per edge", 32'(n_log), 2);
    chk("R10 still enabled", 32'(en[3]), 1);
    per_req[3] = 1'b1; tick(1); per_req[3] = 1'b0; tick(30);
    per_req[3] = 1'b1; tick(1); per_req[3] = 1'b0;
    wait_done(3);
    chk("R10 three edges three units", 32'(n_log), 6);
    chk("R10 done", 32'(done[3]), 1);

    // R8: demand mode, external pin level
    n_log = 0;
    load_ch(0, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 16'd10, 8'd1, 32'hD00, 32'hE00, 1'b1);
    tick(30);
    chk("R8 idle while low", 32'(n_log), 0);
    ext_req[0] = 1'b1;
    for (int k = 0; k < 500 && n_log < 6; k++) @(negedge clk);
    ext_req[0] = 1'b0;
    tick(30);
    chk("R8 unit completes after drop", 32'(n_log % 2), 0);
    chk("R8 stops below count", 32'(n_log < 20), 1);
    chk("R8 still enabled", 32'(en[0]), 1);
    ext_req[0] = 1'b1;
    wait_done(0);
    ext_req[0] = 1'b0;
    chk("R8 total units", 32'(n_log), 20);
    chk("R8 last dst", lg_addr[19], nth(32'hE00, 2'd0, 2'd1, 9));

    // R11: block mode, 3 units per edge, count 7
    n_log = 0;
    load_ch(4, 2'd3, 2'd2, 2'd0, 2'd0, 2'd2, 16'd7, 8'd3, 32'h1100, 32'h1200, 1'b1);
    sw_start[4] = 1'b1; tick(1); sw_start[4] = 1'b0; tick(40);
    chk("R11 first block", 32'(n_log), 6);
    sw_start[4] = 1'b1; tick(1); sw_start[4] = 1'b0; tick(40);
    chk("R11 second block", 32'(n_log), 12);
    chk("R11 enabled between blocks", 32'(en[4]), 1);
    sw_start[4] = 1'b1; tick(1); sw_start[4] = 1'b0;
    wait_done(4);
    chk("R11 short last block", 32'(n_log), 14);
    chk("R11 done", 32'(done[4]), 1);

    // R12: simultaneous start, lower index drains first
    n_log = 0;
    load_ch(3, 2'd1, 2'd2, 2'd0, 2'd0, 2'd2, 16'd2, 8'd1, 32'h1300, 32'h1400, 1'b0);
    load_ch(1, 2'd1, 2'd2, 2'd0, 2'd0, 2'd2, 16'd2, 8'd1, 32'h1500, 32'h1600, 1'b0);
    sw_start[3] = 1'b1; sw_start[1] = 1'b1; tick(1);
    sw_start[3] = 1'b0; sw_start[1] = 1'b0;
    wait_done(3);
    for (int i = 0; i < 8; i++)
      chk("R12 drain order", 32'(lg_ch[i]), (i < 4) ? 1 : 3);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule